// File: doc/BRIEF.md
# Multiplexed Receive Character Silo

This block gathers characters from a set of serial receiver lines into one shared first-in first-out store. Each receiver presents a finished character together with its parity and framing error flags as a one-cycle strobe. The block parks that character in a one-deep holding slot for its line. A round-robin arbiter then moves one parked character per cycle into the shared store, tagged with the number of its line.

Software reaches the block through a small register port with three registers. Reading the character register returns the oldest stored entry and removes it. The control register holds a receive-interrupt enable. The alarm register holds a fill threshold. The interrupt line rises once the number of stored entries goes above the threshold, so software can take characters in batches rather than one interrupt per character. Characters lost to a full store or to a busy holding slot are reported through an overrun flag in the returned word.

Top module: `silo_top`

## Requirements
- R1: After reset the store is empty, the interrupt line is low, the enable bit and the alarm level are zero, and every register reads as 0x0000.
- R2: A word read from address 0 while the store holds entries has bit 15 set, bit 14 overrun, bit 13 framing error, bit 12 parity error, bits 11:8 the source line number and bits 7:0 the character.
- R3: Each read of address 0 removes exactly one entry, and entries come back in the order they were stored.
- R4: A read of address 0 while the store is empty returns 0x0000 and changes nothing.
- R5: A strobe is parked in its line's holding slot and stored no earlier than the following clock edge. A strobe that arrives while its line's slot is still occupied and not being moved in that cycle is dropped, and bit 14 is set on the parked character.
- R6: At most one parked character is stored per cycle. Lines are served round-robin, with the search starting at the line after the last one served (line 0 after reset).
- R7: The store holds 16 entries. A character moved while the store is full and no read takes place is dropped, and bit 14 is set on the next entry stored. A store and a read in the same cycle on a full store both take effect.
- R8: Address 1 bit 6 is the receive-interrupt enable and address 2 bits 5:0 the alarm level. Both read back what was written, and other bits read as zero. A write to address 0 has no effect.
- R9: The interrupt line is high exactly when the enable bit is set and the entry count is greater than the alarm level. A level of 0 therefore raises it for any non-empty store.
- R10: The interrupt line falls as soon as reads bring the count down to the alarm level or below, or as soon as the enable bit is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineStrobe | input | 16 | One-cycle character-ready pulse per line |
| lineChar | input | 128 | Characters, 8 bits per line, line 0 in the low bits |
| lineParErr | input | 1 per line (16) | Parity error flag per line, valid with the strobe |
| lineFrmErr | input | 1 per line (16) | Framing error (break) flag per line, valid with the strobe |
| busAddr | input | 2 | Register address: 0 character, 1 control, 2 alarm |
| busRd | input | 1 | Read strobe; pops the store when the address is 0 |
| busWr | input | 1 | Write strobe |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data for the addressed register |
| rxIrq | output | 1 | Receive interrupt request |

## Verification
The cases of interest are those where two events fall in the same cycle. One is a store and a removal on a full store. The bench starts a strobe and, one cycle later, a read, so both hit the same edge. It then judges by whether the new character survives and is returned after exactly sixteen further reads. Two further cases are a new strobe on a line whose slot is still waiting for the arbiter, and two lines ready together. For these the bench fixes the expected order and overrun marks beforehand in its scoreboard queue, and compares every popped word against it.

// File: rtl/silo_pkg.sv
package silo_pkg;
  localparam int WORD_W       = 16;
  localparam int BIT_VALID    = 15;
  localparam int BIT_OVR      = 14;
  localparam int BIT_FRM      = 13;
  localparam int BIT_PAR      = 12;
  localparam int LINE_LSB     = 8;
  localparam int LINE_FIELD_W = 4;
  localparam int CHAR_FIELD_W = 8;
  localparam int CTRL_IE_BIT  = 6;
  localparam int ALARM_W      = 6;

  localparam logic [1:0] ADDR_CHAR  = 2'd0;
  localparam logic [1:0] ADDR_CTRL  = 2'd1;
  localparam logic [1:0] ADDR_ALARM = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic                    push;
    logic                    pop;
    logic                    grantValid;
    logic [LINE_FIELD_W-1:0] grantLine;
    logic                    addOvr;
  } siloStrb_t;
endpackage

// File: rtl/silo_dp.sv
module silo_dp
  import silo_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int CHAR_W    = 8,
  parameter int DEPTH     = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_LINES-1:0]        lineStrobe,
  input  logic [NUM_LINES*CHAR_W-1:0] lineChar,
  input  logic [NUM_LINES-1:0]        lineParErr,
  input  logic [NUM_LINES-1:0]        lineFrmErr,
  input  siloStrb_t                   strb,
  output logic [NUM_LINES-1:0]        holdValid,
  output logic [WORD_W-1:0]           headWord
);
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int LINE_W = $clog2(NUM_LINES);

  logic [CHAR_W-1:0] holdChar [NUM_LINES];
  logic [NUM_LINES-1:0] holdPar, holdFrm, holdOvr;

  // one-deep holding slot per line
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_hold
    logic granted;
    assign granted = strb.grantValid && (strb.grantLine == LINE_FIELD_W'(i));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        holdValid[i] <= 1'b0;
        holdChar[i]  <= '0;
        holdPar[i]   <= 1'b0;
        holdFrm[i]   <= 1'b0;
        holdOvr[i]   <= 1'b0;
      end else if (lineStrobe[i] && (!holdValid[i] || granted)) begin
        holdValid[i] <= 1'b1;
        holdChar[i]  <= lineChar[i*CHAR_W +: CHAR_W];
        holdPar[i]   <= lineParErr[i];
        holdFrm[i]   <= lineFrmErr[i];
        holdOvr[i]   <= 1'b0;
      end else if (lineStrobe[i]) begin
        holdOvr[i]   <= 1'b1;
      end else if (granted) begin
        holdValid[i] <= 1'b0;
      end
    end
  end

  // entry assembly for the granted line
  logic [LINE_W-1:0]       selLine;
  logic [CHAR_FIELD_W-1:0] charField;
  logic [WORD_W-1:0]       newWord;

  assign selLine = strb.grantLine[LINE_W-1:0];

  always_comb begin
    charField = '0;
    charField[CHAR_W-1:0] = holdChar[selLine];
    newWord = '0;
    newWord[BIT_VALID] = 1'b1;
    newWord[BIT_OVR]   = holdOvr[selLine] | strb.addOvr;
    newWord[BIT_FRM]   = holdFrm[selLine];
    newWord[BIT_PAR]   = holdPar[selLine];
    newWord[LINE_LSB +: LINE_FIELD_W] = strb.grantLine;
    newWord[CHAR_FIELD_W-1:0] = charField;
  end

  // shared storage ring
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.push) wrPtr <= wrPtr + 1'b1;
      if (strb.pop)  rdPtr <= rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrPtr] <= newWord;
  end

  assign headWord = mem[rdPtr];
endmodule

// File: rtl/silo_ctrl.sv
module silo_ctrl
  import silo_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int DEPTH     = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_LINES-1:0]        holdValid,
  input  logic [WORD_W-1:0]           headWord,
  input  logic [1:0]                  busAddr,
  input  logic                        busRd,
  input  logic                        busWr,
  input  logic [WORD_W-1:0]           busWrData,
  output logic [WORD_W-1:0]           busRdData,
  output logic                        rxIrq,
  output siloStrb_t                   strb,
  output logic [$clog2(DEPTH+1)-1:0]  fillLevel,
  output logic [ALARM_W-1:0]          alarmLevel,
  output logic                        intEn
);
  localparam int LINE_W = $clog2(NUM_LINES);
  localparam int CNT_W  = $clog2(DEPTH+1);

  // round-robin search
  logic [LINE_W-1:0] rrPtr, gLine, idx;
  logic              found;

  always_comb begin
    found = 1'b0;
    gLine = '0;
    idx   = '0;
    for (int k = 0; k < NUM_LINES; k++) begin
      idx = LINE_W'((int'(rrPtr) + k) % NUM_LINES);
      if (!found && holdValid[idx]) begin
        found = 1'b1;
        gLine = idx;
      end
    end
  end

  logic empty, full, pop, push, drop, ovrArm;

  assign empty = (fillLevel == '0);
  assign full  = (fillLevel == CNT_W'(DEPTH));
  assign pop   = busRd && (busAddr == ADDR_CHAR) && !empty;
  assign push  = found && (!full || pop);
  assign drop  = found && full && !pop;

  always_comb begin
    strb            = '0;
    strb.push       = push;
    strb.pop        = pop;
    strb.grantValid = found;
    strb.grantLine  = LINE_FIELD_W'(gLine);
    strb.addOvr     = ovrArm;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr     <= '0;
      fillLevel <= '0;
      ovrArm    <= 1'b0;
      intEn     <= 1'b0;
      alarmLevel <= '0;
    end else begin
      if (found) rrPtr <= gLine + 1'b1;
      case ({push, pop})
        2'b10:   fillLevel <= fillLevel + 1'b1;
        2'b01:   fillLevel <= fillLevel - 1'b1;
        default: fillLevel <= fillLevel;
      endcase
      if (drop)      ovrArm <= 1'b1;
      else if (push) ovrArm <= 1'b0;
      if (busWr && busAddr == ADDR_CTRL)  intEn <= busWrData[CTRL_IE_BIT];
      if (busWr && busAddr == ADDR_ALARM) alarmLevel <= busWrData[ALARM_W-1:0];
    end
  end

  always_comb begin
    busRdData = '0;
    case (busAddr)
      ADDR_CHAR:  busRdData = empty ? '0 : headWord;
      ADDR_CTRL:  busRdData[CTRL_IE_BIT] = intEn;
      ADDR_ALARM: busRdData[ALARM_W-1:0] = alarmLevel;
      default:    busRdData = '0;
    endcase
  end

  always_comb begin
    if (alarmLevel == '0) rxIrq = intEn && !empty;
    else                  rxIrq = intEn && (int'(fillLevel) > int'(alarmLevel));
  end
endmodule

// File: rtl/silo_top.sv
module silo_top
  import silo_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int CHAR_W    = 8,
  parameter int DEPTH     = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_LINES-1:0]        lineStrobe,
  input  logic [NUM_LINES*CHAR_W-1:0] lineChar,
  input  logic [NUM_LINES-1:0]        lineParErr,
  input  logic [NUM_LINES-1:0]        lineFrmErr,
  input  logic [1:0]                  busAddr,
  input  logic                        busRd,
  input  logic                        busWr,
  input  logic [15:0]                 busWrData,
  output logic [15:0]                 busRdData,
  output logic                        rxIrq
);
  localparam int CNT_W = $clog2(DEPTH+1);

  siloStrb_t             strb;
  logic [NUM_LINES-1:0]  holdValid;
  logic [WORD_W-1:0]     headWord;
  logic [CNT_W-1:0]      fillLevel;
  logic [ALARM_W-1:0]    alarmLevel;
  logic                  intEn;
  logic                  pushStrb, popStrb;

  assign pushStrb = strb.push;
  assign popStrb  = strb.pop;

  silo_ctrl #(.NUM_LINES(NUM_LINES), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .holdValid(holdValid), .headWord(headWord),
    .busAddr(busAddr), .busRd(busRd), .busWr(busWr), .busWrData(busWrData),
    .busRdData(busRdData), .rxIrq(rxIrq), .strb(strb),
    .fillLevel(fillLevel), .alarmLevel(alarmLevel), .intEn(intEn)
  );

  silo_dp #(.NUM_LINES(NUM_LINES), .CHAR_W(CHAR_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .lineStrobe(lineStrobe), .lineChar(lineChar),
    .lineParErr(lineParErr), .lineFrmErr(lineFrmErr), .strb(strb),
    .holdValid(holdValid), .headWord(headWord)
  );
endmodule

// File: rtl/silo_chk.sv
module silo_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [1:0]                 busAddr,
  input logic [15:0]                busRdData,
  input logic                       rxIrq,
  input logic [$clog2(DEPTH+1)-1:0] fillLevel,
  input logic                       intEn,
  input logic                       pushStrb,
  input logic                       popStrb
);
  localparam int CNT_W = $clog2(DEPTH+1);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN) fillLevel <= CNT_W'(DEPTH)); // R7
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 2'd0 && fillLevel == '0) |-> busRdData == 16'h0000); // R4
  AST_VALID_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 2'd0 && fillLevel != '0) |-> busRdData[15]); // R2
  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (popStrb && !pushStrb) |=> fillLevel == $past(fillLevel) - 1'b1); // R3
  AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (popStrb && pushStrb) |=> $stable(fillLevel)); // R7
  AST_IRQ_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> fillLevel != '0); // R9
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !intEn |-> !rxIrq); // R10
endmodule

bind silo_top silo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRdData(busRdData),
  .rxIrq(rxIrq), .fillLevel(fillLevel), .intEn(intEn),
  .pushStrb(pushStrb), .popStrb(popStrb)
);

// File: tb/tb_silo_top.sv
module tb_silo_top;
  localparam int NL = 16;
  localparam int CW = 8;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NL-1:0]   lineStrobe = '0;
  logic [NL*CW-1:0] lineChar = '0;
  logic [NL-1:0]   lineParErr = '0;
  logic [NL-1:0]   lineFrmErr = '0;
  logic [1:0]      busAddr = 2'd0;
  logic            busRd = 1'b0;
  logic            busWr = 1'b0;
  logic [15:0]     busWrData = '0;
  logic [15:0]     busRdData;
  logic            rxIrq;

  int testsRun = 0;
  int testsFail = 0;
  logic [15:0] expQ [$];

  always #10 clk = ~clk;

  silo_top dut (.*);

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    testsRun++;
    if (!ok) begin
      testsFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mkWord(input int line, input logic [7:0] ch,
                                         input bit par, input bit frm, input bit ovr);
    return {1'b1, ovr, frm, par, 4'(line), ch};
  endfunction

  // monitor: every pop of address 0 is compared with the scoreboard head
  always @(posedge clk) begin
    if (rstN && busRd && busAddr == 2'd0) begin
      logic [15:0] e;
      e = (expQ.size() > 0) ? expQ.pop_front() : 16'h0000;
      check(busRdData === e, "R2/R3/R4 popped word", busRdData, e);
    end
  end

  // all tasks start just after a falling edge
  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    waitN(3);
    rstN = 1'b1;
    expQ.delete();
    waitN(1);
  endtask

  task automatic sendChar(input int line, input logic [7:0] ch, input bit par,
                          input bit frm, input bit ovr, input bit expStored);
    lineStrobe[line] = 1'b1;
    lineChar[line*CW +: CW] = ch;
    lineParErr[line] = par;
    lineFrmErr[line] = frm;
    if (expStored) expQ.push_back(mkWord(line, ch, par, frm, ovr));
    @(negedge clk);
    lineStrobe = '0;
    lineParErr = '0;
    lineFrmErr = '0;
  endtask

  task automatic readChar();
    busAddr = 2'd0;
    busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [15:0] d);
    busAddr = a;
    busWrData = d;
    busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
    busAddr = 2'd0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [15:0] d);
    busAddr = a;
    #1 d = busRdData;
    @(negedge clk);
    busAddr = 2'd0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testsFail++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    @(negedge clk);
    doReset();

    // R1 reset state
    check(rxIrq === 1'b0, "R1 irq after reset", {15'h0, rxIrq}, 16'h0);
    regRead(2'd1, rd); check(rd === 16'h0000, "R1 control after reset", rd, 16'h0000);
    regRead(2'd2, rd); check(rd === 16'h0000, "R1 alarm after reset", rd, 16'h0000);
    readChar(); // R4 empty read, monitor expects 0

    // R8 register readback
    regWrite(2'd1, 16'hFFFF);
    regRead(2'd1, rd); check(rd === 16'h0040, "R8 control readback", rd, 16'h0040);
    regWrite(2'd2, 16'h0023);
    regRead(2'd2, rd); check(rd === 16'h0023, "R8 alarm readback", rd, 16'h0023);
    regWrite(2'd2, 16'hFFFF);
    regRead(2'd2, rd); check(rd === 16'h003F, "R8 alarm field width", rd, 16'h003F);

    // R2 flags and line field
    doReset();
    sendChar(15, 8'hA5, 1'b1, 1'b1, 1'b0, 1'b1);
    sendChar(0, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b1);
    sendChar(6, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1);
    waitN(3);
    busAddr = 2'd0;
    #1 check(busRdData === 16'hBFA5, "R2 head word layout", busRdData, 16'hBFA5);
    repeat (4) readChar(); // R3 order, R4 extra empty read

    // R5 busy holding slot: lines 0,1,2 together, line 2 again next cycle
    doReset();
    lineStrobe = 16'h0007;
    lineChar[0 +: 8] = 8'h11; lineChar[8 +: 8] = 8'h22; lineChar[16 +: 8] = 8'h33;
    @(negedge clk);
    lineStrobe = 16'h0004;
    lineChar[16 +: 8] = 8'h44;
    @(negedge clk);
    lineStrobe = '0;
    expQ.push_back(mkWord(0, 8'h11, 0, 0, 0));
    expQ.push_back(mkWord(1, 8'h22, 0, 0, 0));
    expQ.push_back(mkWord(2, 8'h33, 0, 0, 1)); // R5 new char dropped, overrun set
    waitN(4);
    repeat (4) readChar();

    // R6 round-robin: serve line 9, then lines 3 and 12 together -> 12 first
    doReset();
    sendChar(9, 8'h99, 0, 0, 0, 1'b1);
    waitN(2);
    lineStrobe = 16'h1008;
    lineChar[3*8 +: 8] = 8'h03; lineChar[12*8 +: 8] = 8'h0C;
    expQ.push_back(mkWord(12, 8'h0C, 0, 0, 0)); // R6
    expQ.push_back(mkWord(3, 8'h03, 0, 0, 0));
    @(negedge clk);
    lineStrobe = '0;
    waitN(3);
    repeat (4) readChar();

    // R7 fill to 16, then store+pop in one cycle at full, then drop
    doReset();
    for (int n = 0; n < 16; n++) sendChar(n, 8'(n * 7 + 1), n[0], 1'b0, 1'b0, 1'b1);
    waitN(3);
    fork
      sendChar(5, 8'hE7, 0, 0, 0, 1'b1);
      begin @(negedge clk); readChar(); end
    join
    waitN(3);
    sendChar(7, 8'hD0, 0, 0, 0, 1'b0); // dropped, store full
    waitN(3);
    readChar();
    waitN(1);
    sendChar(8, 8'hC8, 0, 0, 1'b1, 1'b1); // R7 overrun on next stored entry
    waitN(3);
    for (int n = 0; n < 16; n++) readChar();
    readChar(); // empty again, expect 0
    check(expQ.size() == 0, "R7 scoreboard drained", 16'(expQ.size()), 16'h0);

    // R9/R10 interrupt threshold
    doReset();
    regWrite(2'd2, 16'd3);
    for (int n = 0; n < 4; n++) sendChar(n, 8'h40 + 8'(n), 0, 0, 0, 1'b1);
    waitN(3);
    check(rxIrq === 1'b0, "R9 disabled irq stays low", {15'h0, rxIrq}, 16'h0);
    regWrite(2'd1, 16'h0040);
    check(rxIrq === 1'b1, "R9 count 4 above level 3", {15'h0, rxIrq}, 16'h1);
    regWrite(2'd0, 16'hFFFF); // R8 ignored write
    check(rxIrq === 1'b1, "R8 write to char reg ignored", {15'h0, rxIrq}, 16'h1);
    readChar();
    check(rxIrq === 1'b0, "R10 count 3 not above 3", {15'h0, rxIrq}, 16'h0);
    regWrite(2'd2, 16'd0);
    check(rxIrq === 1'b1, "R9 level 0 with entries", {15'h0, rxIrq}, 16'h1);
    regWrite(2'd1, 16'h0000);
    check(rxIrq === 1'b0, "R10 enable cleared", {15'h0, rxIrq}, 16'h0);
    regWrite(2'd1, 16'h0040);
    repeat (3) readChar();
    check(rxIrq === 1'b0, "R10 drained to empty", {15'h0, rxIrq}, 16'h0);
    sendChar(11, 8'h5A, 0, 0, 0, 1'b1);
    waitN(2);
    check(rxIrq === 1'b1, "R9 single entry at level 0", {15'h0, rxIrq}, 16'h1);
    readChar();
    check(expQ.size() == 0, "R3 all entries returned", 16'(expQ.size()), 16'h0);

    waitN(2);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end
endmodule